// File: doc/BRIEF.md
# Serially Programmed Per-Signal Delay Bank

This block sits ahead of a pixel blending datapath and lets each of its five inputs be held back by its own number of clock cycles. The five inputs are two 12-bit pixel streams, a 12-bit blend weight, a 1-bit number-format flag and a 2-bit rounding selector. Every signal passes through its own delay line. The line taps from zero to seven stages, so the five inputs can be realigned when they arrive skewed. The blending arithmetic is not part of this block. The block only delivers the five delayed signals.

The tap lengths come from a 15-bit configuration word that is loaded one bit per strobe. The strobe and its data bit are brought into the main clock domain through two-flop synchronisers. A two-state loader machine then turns each rising strobe into exactly one shift. Its states are `LD_ARMED`, which waits for the strobe to go high, and `LD_HELD`, which waits for it to go low. The transition `LD_ARMED -> LD_HELD` fires on a synchronised high strobe and performs the shift. The transition `LD_HELD -> LD_ARMED` fires on a synchronised low strobe. A bypass input clears the word and holds it at zero while high. Reset also clears the word, together with every delay stage.

Top module: `tap_delay_bank`

## Requirements
- R1: The configuration word has five 3-bit fields, each an unsigned delay length. Bits 2..0 set pixel A, bits 5..3 set pixel B, bits 8..6 set the weight, bits 11..9 set the format flag and bits 14..12 set the rounding selector.
- R2: Each rising edge of `cfg_strobe` shifts `cfg_bit` into bit 14 and moves every bit one place toward bit 0. The first of 15 loaded bits therefore ends at bit 0.
- R3: A strobe held high for any number of clocks produces exactly one shift. `cfg_bit` must be steady from two clocks before the strobe rises until three clocks after it falls.
- R4: With a field value d from 1 to 7, the output equals the input d clock edges earlier.
- R5: With a field value of 0, the output follows the input in the same cycle, with no register.
- R6: While `bypass` is high, the word reads zero from the next clock on and strobes have no effect. After `bypass` falls, every line has zero delay until a new load.
- R7: After reset, all fields are zero, so every output follows its input.
- R8: The five lines are independent: different delays set at the same time each apply only to their own signal.
- R9: Loading binary 100 into bits 5..3 and zeros elsewhere delays pixel B by four cycles and leaves the other four lines undelayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock for the delay stages and the loader |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_strobe | input | 1 | Load strobe; each rising edge shifts once |
| bypass | input | 1 | Clears the configuration word while high |
| pix_a_i | input | 12 | Pixel stream A |
| pix_b_i | input | 12 | Pixel stream B |
| alpha_i | input | 12 | Blend weight |
| fmt_i | input | 1 | Number-format flag |
| rnd_i | input | 2 | Rounding selector |
| pix_a_o | output | 12 | Delayed pixel A |
| pix_b_o | output | 12 | Delayed pixel B |
| alpha_o | output | 12 | Delayed blend weight |
| fmt_o | output | 1 | Delayed format flag |
| rnd_o | output | 2 | Delayed rounding selector |

## Verification
A new value driven onto an input is due at its output after exactly d rising edges, where d is the field value; with d of 0 it is due in the same cycle. The bench drives one new input set per cycle and keeps a 16-entry history of those sets. Shortly after each drive it compares every output with the history entry d cycles back. A strobe changes the configuration word three clocks after it rises, so checks resume only once a load has settled. Settings of 0 and 7 are included on every line, and checks start only after seven cycles of history exist.

// File: rtl/tdb_pkg.sv
package tdb_pkg;
    localparam int NUM_LINES = 5;
    localparam int FIELD_W   = 3;
    localparam int CFG_W     = NUM_LINES * FIELD_W;
    localparam int SYNC_W    = 2;

    // field positions inside the configuration word (decoded by the lines)
    localparam int FLD_PIX_A = 0;
    localparam int FLD_PIX_B = 1;
    localparam int FLD_ALPHA = 2;
    localparam int FLD_FMT   = 3;
    localparam int FLD_RND   = 4;

    typedef enum logic {
        LD_ARMED = 1'b0,
        LD_HELD  = 1'b1
    } ld_state_t;
endpackage

// File: rtl/tdb_sync.sv
module tdb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= d;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/tdb_loader.sv
module tdb_loader
    import tdb_pkg::*;
#(
    parameter int WORD_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              strb_s,
    input  logic              bit_s,
    output logic              shift_en,
    output logic [WORD_W-1:0] cfg_q
);
    ld_state_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_ARMED;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            LD_ARMED: if (strb_s)  state_nx = LD_HELD;
            LD_HELD:  if (!strb_s) state_nx = LD_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        shift_en = 1'b0;
        unique case (state)
            LD_ARMED: shift_en = strb_s;
            LD_HELD:  shift_en = 1'b0;
        endcase
    end

    // configuration word: newest bit enters at the top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_q <= '0;
        else if (bypass)   cfg_q <= '0;
        else if (shift_en) cfg_q <= {bit_s, cfg_q[WORD_W-1:1]};
    end
endmodule

// File: rtl/tdb_line.sv
module tdb_line #(
    parameter int W     = 12,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);
    localparam int DEPTH = (1 << SEL_W) - 1;

    logic [W-1:0] stg [1:DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 1; k <= DEPTH; k++) stg[k] <= '0;
        end else begin
            stg[1] <= din;
            for (int k = 2; k <= DEPTH; k++) stg[k] <= stg[k-1];
        end
    end

    always_comb begin
        dout = din;
        for (int k = 1; k <= DEPTH; k++)
            if (sel == SEL_W'(k)) dout = stg[k];
    end
endmodule

// File: rtl/tap_delay_bank.sv
module tap_delay_bank
    import tdb_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int ALPHA_W = 12,
    parameter int FMT_W   = 1,
    parameter int RND_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_bit,
    input  logic               cfg_strobe,
    input  logic               bypass,
    input  logic [PIX_W-1:0]   pix_a_i,
    input  logic [PIX_W-1:0]   pix_b_i,
    input  logic [ALPHA_W-1:0] alpha_i,
    input  logic [FMT_W-1:0]   fmt_i,
    input  logic [RND_W-1:0]   rnd_i,
    output logic [PIX_W-1:0]   pix_a_o,
    output logic [PIX_W-1:0]   pix_b_o,
    output logic [ALPHA_W-1:0] alpha_o,
    output logic [FMT_W-1:0]   fmt_o,
    output logic [RND_W-1:0]   rnd_o
);
    logic [1:0]       sync_q;
    logic             strb_s;
    logic             bit_s;
    logic             shift_en;
    logic [CFG_W-1:0] cfg_q;

    tdb_sync #(.W(2), .STAGES(SYNC_W)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cfg_strobe, cfg_bit}), .q(sync_q)
    );
    assign strb_s = sync_q[1];
    assign bit_s  = sync_q[0];

    tdb_loader #(.WORD_W(CFG_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .bypass(bypass),
        .strb_s(strb_s), .bit_s(bit_s),
        .shift_en(shift_en), .cfg_q(cfg_q)
    );

    tdb_line #(.W(PIX_W), .SEL_W(FIELD_W)) u_line_a (
        .clk(clk), .rst_n(rst_n),
        .sel(cfg_q[FLD_PIX_A*FIELD_W +: FIELD_W]),
        .din(pix_a_i), .dout(pix_a_o)
    );
    tdb_line #(.W(PIX_W), .SEL_W(FIELD_W)) u_line_b (
        .clk(clk), .rst_n(rst_n),
        .sel(cfg_q[FLD_PIX_B*FIELD_W +: FIELD_W]),
        .din(pix_b_i), .dout(pix_b_o)
    );
    tdb_line #(.W(ALPHA_W), .SEL_W(FIELD_W)) u_line_alpha (
        .clk(clk), .rst_n(rst_n),
        .sel(cfg_q[FLD_ALPHA*FIELD_W +: FIELD_W]),
        .din(alpha_i), .dout(alpha_o)
    );
    tdb_line #(.W(FMT_W), .SEL_W(FIELD_W)) u_line_fmt (
        .clk(clk), .rst_n(rst_n),
        .sel(cfg_q[FLD_FMT*FIELD_W +: FIELD_W]),
        .din(fmt_i), .dout(fmt_o)
    );
    tdb_line #(.W(RND_W), .SEL_W(FIELD_W)) u_line_rnd (
        .clk(clk), .rst_n(rst_n),
        .sel(cfg_q[FLD_RND*FIELD_W +: FIELD_W]),
        .din(rnd_i), .dout(rnd_o)
    );
endmodule

// File: rtl/tdb_chk.sv
module tdb_chk #(
    parameter int PIX_W = 12,
    parameter int CFG_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bypass,
    input logic             shift_en,
    input logic             bit_s,
    input logic [CFG_W-1:0] cfg_q,
    input logic [PIX_W-1:0] pix_a_i,
    input logic [PIX_W-1:0] pix_a_o
);
    // R6
    bypass_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (cfg_q == '0));

    // R2
    shift_enters_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !bypass) |=> (cfg_q[CFG_W-1] == $past(bit_s)));

    // R3
    single_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> !shift_en);

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !bypass) |=> $stable(cfg_q));

    // R5
    zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[2:0] == 3'd0) |-> (pix_a_o == pix_a_i));

    // R4
    one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[2:0] == 3'd1 && $past(cfg_q[2:0]) == 3'd1) |-> (pix_a_o == $past(pix_a_i)));
endmodule

bind tap_delay_bank tdb_chk #(.PIX_W(PIX_W), .CFG_W(tdb_pkg::CFG_W)) u_tdb_chk (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .shift_en(shift_en),
    .bit_s(bit_s), .cfg_q(cfg_q), .pix_a_i(pix_a_i), .pix_a_o(pix_a_o)
);

// File: tb/test_tap_delay_bank.sv
module test_tap_delay_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bit = 1'b0;
    logic        cfg_strobe = 1'b0;
    logic        bypass = 1'b0;
    logic [11:0] pix_a_i = '0, pix_b_i = '0, alpha_i = '0;
    logic        fmt_i = 1'b0;
    logic [1:0]  rnd_i = '0;
    logic [11:0] pix_a_o, pix_b_o, alpha_o;
    logic        fmt_o;
    logic [1:0]  rnd_o;

    int vectors = 0;
    int fails = 0;
    int n = 0;
    int dly [5];
    logic [38:0] hist [16];

    always #5 clk = ~clk;

    tap_delay_bank i_tap_delay_bank (
        .clk(clk), .rst_n(rst_n), .cfg_bit(cfg_bit), .cfg_strobe(cfg_strobe),
        .bypass(bypass), .pix_a_i(pix_a_i), .pix_b_i(pix_b_i), .alpha_i(alpha_i),
        .fmt_i(fmt_i), .rnd_i(rnd_i), .pix_a_o(pix_a_o), .pix_b_o(pix_b_o),
        .alpha_o(alpha_o), .fmt_o(fmt_o), .rnd_o(rnd_o)
    );

    task automatic cmp(input string req, input string nm, input logic [11:0] got, input logic [11:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d: got %h expected %h", req, nm, n, got, exp);
        end
    endtask

    task automatic tick(input bit chk, input string req);
        logic [38:0] v;
        @(negedge clk);
        n++;
        v[38:27] = 12'((n * 113 + 7) & 12'hfff);
        v[26:15] = 12'((n * 2749) ^ 12'ha5a);
        v[14:3]  = 12'((n * 59 + 301) & 12'hfff);
        v[2]     = 1'(n ^ (n >> 3));
        v[1:0]   = 2'((n * 3) >> 1);
        {pix_a_i, pix_b_i, alpha_i, fmt_i, rnd_i} = v;
        hist[n & 15] = v;
        #1;
        if (chk) begin
            cmp(req, "pix_a", pix_a_o,          hist[(n - dly[0]) & 15][38:27]);
            cmp(req, "pix_b", pix_b_o,          hist[(n - dly[1]) & 15][26:15]);
            cmp(req, "alpha", alpha_o,          hist[(n - dly[2]) & 15][14:3]);
            cmp(req, "fmt",   12'(fmt_o),       12'(hist[(n - dly[3]) & 15][2]));
            cmp(req, "rnd",   12'(rnd_o),       12'(hist[(n - dly[4]) & 15][1:0]));
        end
    endtask

    task automatic load(input logic [14:0] w, input int hold);
        for (int i = 0; i < 15; i++) begin
            cfg_bit = w[i];
            tick(0, "");
            tick(0, "");
            cfg_strobe = 1'b1;
            for (int h = 0; h < hold; h++) tick(0, "");
            cfg_strobe = 1'b0;
            for (int h = 0; h < 3; h++) tick(0, "");
        end
        for (int h = 0; h < 3; h++) tick(0, "");
    endtask

    function automatic logic [14:0] pack_cfg();
        logic [14:0] w = '0;
        for (int i = 0; i < 5; i++) w[i*3 +: 3] = 3'(dly[i]);
        return w;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 5; i++) dly[i] = 0;
        for (int i = 0; i < 10; i++) tick(0, "");
        rst_n = 1'b1;
        // R7: cleared word, every output follows its input
        for (int i = 0; i < 4; i++) tick(1, "R7");

        // R9: 100 into pixel B field only
        dly[1] = 4;
        load(pack_cfg(), 3);
        for (int i = 0; i < 12; i++) tick(1, "R9");

        // R1 R2 R4 R5 R8 sweep: each line visits every length 0..7; R3 long hold
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 5; i++) dly[i] = (k + i) % 8;
            load(pack_cfg(), (k == 3) ? 20 : 3);
            for (int i = 0; i < 20; i++)
                tick(1, (k == 3) ? "R3" : "R1/R2/R4/R5/R8");
        end

        // R6: bypass clears and blocks strobes
        bypass = 1'b1;
        for (int i = 0; i < 5; i++) dly[i] = 0;
        tick(0, "");
        tick(0, "");
        for (int i = 0; i < 4; i++) tick(1, "R6");
        load(15'h7fff, 3);
        for (int i = 0; i < 4; i++) tick(1, "R6");
        bypass = 1'b0;
        for (int i = 0; i < 8; i++) tick(1, "R6");

        summary();
    end
endmodule